// File: doc/BRIEF.md
# Distance-Indexed Page Prefetch Predictor

This block watches the stream of virtual page numbers that reach a translation buffer and learns which page distance usually follows a given distance. Every accepted access is treated the same way, whether or not it hit. The block takes the difference between the new page number and the one before it. It uses that difference to look up a small on-chip table and asks for a translation prefetch at the new page plus every distance the table predicts. It then records the new distance as a successor of the previous distance. Because the table is keyed by the delta and not by the page, a pattern learned in one region applies straight away to pages that have never been seen.

Accesses arrive on a valid/ready port. A prefetch request leaves on a second valid/ready port, one request per cycle. An access is accepted only when no prefetch from the previous access is still waiting. So a held-off prefetch port holds off the access port. An access with k predictions therefore uses 1+k cycles of the access port.

Top module: `dist_prefetch`

## Requirements
- R1: After reset, in_ready is 1, pf_valid is 0, and both the page history and the table are empty.
- R2: The first accepted access after reset only records the page. The second only records the distance. Neither produces a prefetch or changes the table.
- R3: The distance is the current page minus the previous page, taken as a signed two's-complement value. The lookup uses the table contents from before this access's own update. Then the current distance is added as a successor of the previous distance. For the page stream 1,2,4,5,7,8 the prefetches are none,none,none,{7},{8},{10}.
- R4: Negative distances work the same way as positive ones. A prefetch address is the page plus the sign-extended distance, wrapped modulo 2^VPN_W. For 2,1,0,0xFFFFF the last access prefetches 0xFFFFE.
- R5: A repeated page (distance zero) causes no lookup, no table update and no prefetch. It also keeps the last distance.
- R6: Only distances in the range -2^(DIST_W-1) to 2^(DIST_W-1)-1 take part (with DIST_W=8, +128 is out of range and -128 is in range). An out-of-range distance is handled like zero, except that it still becomes the new previous page.
- R7: Each entry keeps up to SLOTS successor distances, most recent first. A successor that is already present moves to the front. A new successor at the front of a full entry pushes out the least recent one. Prefetches leave most-recent first, and there are at most SLOTS per access.
- R8: The table is direct-mapped. The index is the low log2(ENTRIES) bits of the distance, and the tag is the whole distance. A tag mismatch on lookup gives no prefetch. A tag mismatch on update reallocates the entry under the new tag with empty slots before the insert.
- R9: The first prefetch of an access is presented in the cycle after acceptance, and one more follows each cycle that pf_ready is high. While pf_valid is high and pf_ready is low, pf_vpn holds. in_ready stays 0 while any prefetch is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Access offered |
| in_ready | output | 1 | Access can be accepted (no prefetch pending) |
| in_vpn | input | VPN_W | Virtual page number of the access |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Downstream takes the prefetch request |
| pf_vpn | output | VPN_W | Page number to prefetch |

## Verification
The predictor is driven with a short alternating-stride stream, which shows that learning goes from one distance to its successor rather than from a page. Descending streams and a stream that crosses page zero show signed distance and address wrap. Streams with repeated pages and with jumps just past and just inside the distance range separate "ignored" from "learned" and show that the last distance survives. A distance whose several successors are refreshed and evicted checks the slot ordering and the order of issue. Two distances that share an index show reallocation. Holding pf_ready low during a two-prefetch burst checks the hold of the request and the blocking of new accesses.

// File: rtl/dp_pkg.sv
package dp_pkg;
  // Warm-up phase of the page history
  typedef enum logic [1:0] {
    HIST_EMPTY = 2'd0,  // no page seen yet
    HIST_PAGE  = 2'd1,  // last page known, no distance yet
    HIST_FULL  = 2'd2   // last page and last distance known
  } hist_e;
endpackage

// File: rtl/dp_dist_track.sv
module dp_dist_track
  import dp_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int DIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [VPN_W-1:0]  vpn,
  output logic [DIST_W-1:0] cur_dist,
  output logic [DIST_W-1:0] prev_dist,
  output logic              lookup_en,
  output logic              upd_en
);
  localparam int HI_W = VPN_W - DIST_W + 1;

  logic [VPN_W-1:0]  last_vpn_q;
  logic [DIST_W-1:0] last_dist_q;
  hist_e             phase_q;

  logic [VPN_W-1:0] diff;
  logic [HI_W-1:0]  hi_bits;
  logic             fits, nonzero, dist_ok;

  always_comb begin
    diff     = vpn - last_vpn_q;
    hi_bits  = diff[VPN_W-1:DIST_W-1];
    // signed value fits when all bits above the kept sign agree
    fits     = (&hi_bits) | ~(|hi_bits);
    nonzero  = |diff;
    dist_ok  = (phase_q != HIST_EMPTY) && fits && nonzero;
    cur_dist = diff[DIST_W-1:0];
    prev_dist = last_dist_q;
    lookup_en = acc && dist_ok && (phase_q == HIST_FULL);
    upd_en    = lookup_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_vpn_q  <= '0;
      last_dist_q <= '0;
      phase_q     <= HIST_EMPTY;
    end else if (acc) begin
      last_vpn_q <= vpn;
      if (phase_q == HIST_EMPTY) begin
        phase_q <= HIST_PAGE;
      end else if (dist_ok) begin
        last_dist_q <= cur_dist;
        phase_q     <= HIST_FULL;
      end
    end
  end
endmodule

// File: rtl/dp_lru_insert.sv
module dp_lru_insert #(
  parameter int DIST_W = 8,
  parameter int SLOTS  = 2
) (
  input  logic [SLOTS-1:0]        old_v,
  input  logic [SLOTS*DIST_W-1:0] old_d,
  input  logic [DIST_W-1:0]       new_d,
  output logic [SLOTS-1:0]        nxt_v,
  output logic [SLOTS*DIST_W-1:0] nxt_d
);
  int   lim;
  logic found;

  always_comb begin
    // shift window ends at the matching slot, or at the last slot (evict)
    lim   = SLOTS - 1;
    found = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!found && old_v[i] && (old_d[i*DIST_W +: DIST_W] == new_d)) begin
        lim   = i;
        found = 1'b1;
      end
    end
    nxt_v = old_v;
    nxt_d = old_d;
    for (int i = 1; i < SLOTS; i++) begin
      if (i <= lim) begin
        nxt_v[i]                  = old_v[i-1];
        nxt_d[i*DIST_W +: DIST_W] = old_d[(i-1)*DIST_W +: DIST_W];
      end
    end
    nxt_v[0]          = 1'b1;
    nxt_d[DIST_W-1:0] = new_d;
  end
endmodule

// File: rtl/dp_dist_table.sv
module dp_dist_table #(
  parameter int DIST_W  = 8,
  parameter int ENTRIES = 16,
  parameter int SLOTS   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIST_W-1:0]       lk_dist,
  output logic [SLOTS-1:0]        lk_v,
  output logic [SLOTS*DIST_W-1:0] lk_d,
  input  logic                    upd_en,
  input  logic [DIST_W-1:0]       upd_key,
  input  logic [DIST_W-1:0]       upd_val
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [DIST_W-1:0]       tag_q [ENTRIES];
  logic                    ev_q  [ENTRIES];
  logic [SLOTS-1:0]        sv_q  [ENTRIES];
  logic [SLOTS*DIST_W-1:0] sd_q  [ENTRIES];

  logic [IDX_W-1:0]        lk_idx, up_idx;
  logic                    lk_hit, up_hit;
  logic [SLOTS-1:0]        up_old_v, up_nxt_v;
  logic [SLOTS*DIST_W-1:0] up_nxt_d;

  always_comb begin
    lk_idx = lk_dist[IDX_W-1:0];
    up_idx = upd_key[IDX_W-1:0];
    lk_hit = ev_q[lk_idx] && (tag_q[lk_idx] == lk_dist);
    up_hit = ev_q[up_idx] && (tag_q[up_idx] == upd_key);
    lk_v   = lk_hit ? sv_q[lk_idx] : '0;
    lk_d   = sd_q[lk_idx];
    // a tag mismatch starts the entry over with empty slots
    up_old_v = up_hit ? sv_q[up_idx] : '0;
  end

  dp_lru_insert #(.DIST_W(DIST_W), .SLOTS(SLOTS)) u_ins (
    .old_v (up_old_v),
    .old_d (sd_q[up_idx]),
    .new_d (upd_val),
    .nxt_v (up_nxt_v),
    .nxt_d (up_nxt_d)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[e] <= '0;
        ev_q[e]  <= 1'b0;
        sv_q[e]  <= '0;
        sd_q[e]  <= '0;
      end else if (upd_en && (up_idx == IDX_W'(e))) begin
        tag_q[e] <= upd_key;
        ev_q[e]  <= 1'b1;
        sv_q[e]  <= up_nxt_v;
        sd_q[e]  <= up_nxt_d;
      end
    end
  end
endmodule

// File: rtl/dp_pf_issue.sv
module dp_pf_issue #(
  parameter int VPN_W  = 20,
  parameter int DIST_W = 8,
  parameter int SLOTS  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [VPN_W-1:0]        base_vpn,
  input  logic [SLOTS-1:0]        pred_v,
  input  logic [SLOTS*DIST_W-1:0] pred_d,
  output logic                    pf_valid,
  input  logic                    pf_ready,
  output logic [VPN_W-1:0]        pf_vpn,
  output logic                    busy
);
  localparam int EXT_W = VPN_W - DIST_W;

  logic [SLOTS-1:0] q_v;
  logic [VPN_W-1:0] q_a [SLOTS];
  logic [VPN_W-1:0] tgt [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_tgt
    logic [DIST_W-1:0] d;
    assign d      = pred_d[i*DIST_W +: DIST_W];
    assign tgt[i] = base_vpn + {{EXT_W{d[DIST_W-1]}}, d};
  end

  assign pf_valid = q_v[0];
  assign pf_vpn   = q_a[0];
  assign busy     = |q_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_v <= '0;
      for (int i = 0; i < SLOTS; i++) q_a[i] <= '0;
    end else if (load) begin
      q_v <= pred_v;
      for (int i = 0; i < SLOTS; i++) q_a[i] <= tgt[i];
    end else if (pf_valid && pf_ready) begin
      for (int i = 0; i < SLOTS - 1; i++) begin
        q_v[i] <= q_v[i+1];
        q_a[i] <= q_a[i+1];
      end
      q_v[SLOTS-1] <= 1'b0;
    end
  end
endmodule

// File: rtl/dist_prefetch.sv
module dist_prefetch #(
  parameter int VPN_W   = 20,
  parameter int DIST_W  = 8,
  parameter int ENTRIES = 16,
  parameter int SLOTS   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VPN_W-1:0] in_vpn,
  output logic             pf_valid,
  input  logic             pf_ready,
  output logic [VPN_W-1:0] pf_vpn
);
  logic                    acc, busy;
  logic [DIST_W-1:0]       cur_dist, prev_dist;
  logic                    lookup_en, upd_en;
  logic [SLOTS-1:0]        lk_v;
  logic [SLOTS*DIST_W-1:0] lk_d;

  assign in_ready = !busy;
  assign acc      = in_valid && in_ready;

  dp_dist_track #(.VPN_W(VPN_W), .DIST_W(DIST_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .vpn       (in_vpn),
    .cur_dist  (cur_dist),
    .prev_dist (prev_dist),
    .lookup_en (lookup_en),
    .upd_en    (upd_en)
  );

  dp_dist_table #(.DIST_W(DIST_W), .ENTRIES(ENTRIES), .SLOTS(SLOTS)) u_tab (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_dist (cur_dist),
    .lk_v    (lk_v),
    .lk_d    (lk_d),
    .upd_en  (upd_en),
    .upd_key (prev_dist),
    .upd_val (cur_dist)
  );

  dp_pf_issue #(.VPN_W(VPN_W), .DIST_W(DIST_W), .SLOTS(SLOTS)) u_iss (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (lookup_en),
    .base_vpn (in_vpn),
    .pred_v   (lk_v),
    .pred_d   (lk_d),
    .pf_valid (pf_valid),
    .pf_ready (pf_ready),
    .pf_vpn   (pf_vpn),
    .busy     (busy)
  );
endmodule

// File: rtl/dp_chk.sv
module dp_chk #(
  parameter int VPN_W = 20,
  parameter int SLOTS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [VPN_W-1:0] in_vpn,
  input logic             pf_valid,
  input logic             pf_ready,
  input logic [VPN_W-1:0] pf_vpn
);
  localparam int CW = $clog2(SLOTS + 1) + 1;

  logic             acc;
  logic [1:0]       acc_n;
  logic             seen;
  logic [VPN_W-1:0] last_vpn;
  logic [CW-1:0]    pf_cnt;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_n    <= '0;
      seen     <= 1'b0;
      last_vpn <= '0;
      pf_cnt   <= '0;
    end else begin
      if (acc) begin
        if (acc_n != 2'd2) acc_n <= acc_n + 2'd1;
        seen     <= 1'b1;
        last_vpn <= in_vpn;
        pf_cnt   <= '0;
      end else if (pf_valid && pf_ready) begin
        pf_cnt <= pf_cnt + CW'(1);
      end
    end
  end

  // R9
  pf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_vpn)));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> !in_ready);

  // R2
  warmup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (acc_n != 2'd2)) |=> !pf_valid);

  // R5
  repeat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && seen && (in_vpn == last_vpn)) |=> !pf_valid);

  // R7
  per_access_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready) |-> (pf_cnt < CW'(SLOTS)));
endmodule

bind dist_prefetch dp_chk #(.VPN_W(VPN_W), .SLOTS(SLOTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_vpn   (in_vpn),
  .pf_valid (pf_valid),
  .pf_ready (pf_ready),
  .pf_vpn   (pf_vpn)
);

// File: tb/tb_dist_prefetch.sv
`timescale 1ns/1ps
module tb_dist_prefetch;
  localparam int VW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] in_vpn = '0;
  logic          pf_valid;
  logic          pf_ready = 1'b1;
  logic [VW-1:0] pf_vpn;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int got;
  logic [VW-1:0] g0, g1;

  always #4 clk = ~clk;

  dist_prefetch #(.VPN_W(VW), .DIST_W(8), .ENTRIES(16), .SLOTS(2)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vpn(in_vpn), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_vpn(pf_vpn)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; pf_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(pf_valid == 1'b0, "R1 pf_valid", pf_valid, 0);
  endtask

  task automatic send(input logic [VW-1:0] vpn);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_vpn = vpn;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // sampled at negedges, starting one edge after acceptance (R9 timing)
  task automatic collect();
    got = 0;
    while (pf_valid) begin
      if (pf_ready) begin
        if (got == 0) g0 = pf_vpn;
        if (got == 1) g1 = pf_vpn;
        got++;
      end
      @(negedge clk);
    end
  endtask

  task automatic access(input logic [VW-1:0] vpn, input int n,
                        input logic [VW-1:0] x0, input logic [VW-1:0] x1,
                        input string req);
    send(vpn);
    collect();
    chk(got == n, {req, " count"}, got, n);
    if (n > 0 && got > 0) chk(g0 == x0, {req, " first"}, g0, x0);
    if (n > 1 && got > 1) chk(g1 == x1, {req, " second"}, g1, x1);
  endtask

  task automatic t_warmup();  // R2
    do_reset();
    access(10, 0, 0, 0, "R2 first access");
    access(11, 0, 0, 0, "R2 second access");
    access(12, 0, 0, 0, "R2 unlearned");
    access(13, 1, 14, 0, "R2 learned after warmup");
  endtask

  task automatic t_alt_stride();  // R3
    do_reset();
    access(1, 0, 0, 0, "R3 p1");
    access(2, 0, 0, 0, "R3 p2");
    access(4, 0, 0, 0, "R3 p4");
    access(5, 1, 7, 0, "R3 p5");
    access(7, 1, 8, 0, "R3 p7");
    access(8, 1, 10, 0, "R3 p8");
  endtask

  task automatic t_negative();  // R4
    do_reset();
    access(100, 0, 0, 0, "R4 n100");
    access(97, 0, 0, 0, "R4 n97");
    access(95, 0, 0, 0, "R4 n95");
    access(92, 1, 90, 0, "R4 n92");
    do_reset();
    access(2, 0, 0, 0, "R4 w2");
    access(1, 0, 0, 0, "R4 w1");
    access(0, 0, 0, 0, "R4 w0 read-before-update");
    access(20'hFFFFF, 1, 20'hFFFFE, 0, "R4 wrap");
  endtask

  task automatic t_zero();  // R5
    do_reset();
    access(1, 0, 0, 0, "R5 z1");
    access(2, 0, 0, 0, "R5 z2");
    access(4, 0, 0, 0, "R5 z4");
    access(4, 0, 0, 0, "R5 repeat");
    access(5, 1, 7, 0, "R5 after repeat");
    access(7, 1, 8, 0, "R5 last distance kept");
  endtask

  task automatic t_range();  // R6
    do_reset();
    access(0, 0, 0, 0, "R6 r0");
    access(1, 0, 0, 0, "R6 r1");
    access(3, 0, 0, 0, "R6 r3");
    access(131, 0, 0, 0, "R6 plus128 ignored");
    access(132, 1, 134, 0, "R6 page moved");
    access(4, 0, 0, 0, "R6 minus128 used");
    access(5, 2, 20'hFFF85, 7, "R6 minus128 learned");
  endtask

  task automatic t_lru();  // R7
    do_reset();
    access(0, 0, 0, 0, "R7 l0");
    access(1, 0, 0, 0, "R7 l1");
    access(4, 0, 0, 0, "R7 l4");
    access(5, 1, 8, 0, "R7 l5");
    access(10, 0, 0, 0, "R7 l10");
    access(11, 2, 16, 14, "R7 mru first");
    access(18, 0, 0, 0, "R7 l18");
    access(19, 2, 26, 24, "R7 lru evicted");
    access(24, 1, 25, 0, "R7 l24");
    access(25, 2, 30, 32, "R7 refresh to front");
  endtask

  task automatic t_alias();  // R8
    do_reset();
    access(0, 0, 0, 0, "R8 a0");
    access(1, 0, 0, 0, "R8 a1");
    access(3, 0, 0, 0, "R8 a3");
    access(20, 0, 0, 0, "R8 tag miss lookup");
    access(21, 1, 23, 0, "R8 a21");
    access(22, 0, 0, 0, "R8 reallocated");
    access(23, 1, 24, 0, "R8 relearned");
  endtask

  task automatic t_backpressure();  // R9
    do_reset();
    access(0, 0, 0, 0, "R9 b0");
    access(1, 0, 0, 0, "R9 b1");
    access(3, 0, 0, 0, "R9 b3");
    access(4, 1, 6, 0, "R9 b4");
    access(7, 0, 0, 0, "R9 b7");
    pf_ready = 1'b0;
    send(8);
    for (int k = 0; k < 3; k++) begin
      chk(pf_valid == 1'b1, "R9 held valid", pf_valid, 1);
      chk(pf_vpn == 11, "R9 held address", pf_vpn, 11);
      chk(in_ready == 1'b0, "R9 access blocked", in_ready, 0);
      @(negedge clk);
    end
    pf_ready = 1'b1;
    collect();
    chk(got == 2, "R9 count after release", got, 2);
    if (got > 1) begin
      chk(g0 == 11, "R9 first", g0, 11);
      chk(g1 == 10, "R9 second", g1, 10);
    end
    chk(in_ready == 1'b1, "R9 ready after drain", in_ready, 1);
  endtask

  initial begin
    t_warmup();
    t_alt_stride();
    t_negative();
    t_zero();
    t_range();
    t_lru();
    t_alias();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule